// File: doc/BRIEF.md
# Memory Self-Test Sequencer

This block controls the built-in data-pattern test engine of a DRAM controller during bring-up. One pulse on `start` sets off a full test. For each seed taken from a fixed list of eight words, the sequencer puts the seed on `seed_val` and runs the engine sixteen times. The first eight runs use single transfers and the next eight use bursts, and within each group the data-generator selection counts up from 0 to 7. The control word returns to zero before every run. The sequencer then polls the engine's completion and failure bits and gives up after a bounded number of polls.

A seed passes only when all sixteen of its runs complete cleanly. The first failed run, or the first run that times out, ends that seed at once, counts it as failed, and moves on to the next seed. After the configured number of seeds, the block raises `done` and holds it. It also presents the pass and fail counts and raises `err` when any seed failed. The test engine is external to this block.

Top module: `mst_seq`

## Requirements
- R1: After reset, `eng_ctrl` is 0, `done` and `err` are 0, and both counts are 0.
- R2: The k-th seed of a test (k counted from 0 at each start) appears on `seed_val` as entry k mod 8 of the list 0xcc33cc33, 0xff00ff00, 0xaa55aa55, 0x88778877, 0x92cc4d6e, 0x543d3cde, 0xf1e843c7, 0x7c61d253, and it stays there during that seed's runs.
- R3: For each seed there are at most 16 runs: selections 0..7 in single mode, then selections 0..7 in burst mode, each in ascending order.
- R4: The 8-bit start word is 0x85 | (sel << 3) in single mode and 0xC1 | (sel << 3) in burst mode. `eng_ctrl` carries no other nonzero value.
- R5: `eng_ctrl` is 0 for at least one cycle before each start word appears. It returns to 0 after every run ends, whether the run completed, failed or timed out.
- R6: Status bit 12 means the run completed and status bit 13 means it failed. When both bits are set, the failure takes priority. A failure skips the seed's remaining runs and counts the seed as failed.
- R7: If `POLL_LIMIT` polls pass without bit 12 or bit 13 set, the run times out and the seed counts as failed. A completion seen on the last allowed poll still counts as a pass.
- R8: Each test uses exactly `NUM_SEEDS` seeds. When `done` is high, pass count plus fail count equals `NUM_SEEDS`.
- R9: `done` rises when the last seed has been resolved and stays high until the next accepted start. `err` is high exactly when `done` is high and the fail count is nonzero.
- R10: A `start` pulse while a test is running has no effect. An accepted start clears both counts and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a test; acted on only when idle |
| eng_status | input | STAT_W | Engine status; bit 12 = completed, bit 13 = failed |
| eng_ctrl | output | 8 | Engine control word |
| seed_val | output | 32 | Seed word for the current seed |
| done | output | 1 | Test finished; held until the next start |
| err | output | 1 | Finished with at least one failed seed |
| pass_cnt | output | CNT_W | Number of seeds that passed |
| fail_cnt | output | CNT_W | Number of seeds that failed, which is the test result |

## Verification
The bench builds the block with `NUM_SEEDS` = 10 and `POLL_LIMIT` = 12. Ten seeds make the seed index wrap past the end of the eight-entry list inside one test. The small poll limit means timeouts take a few cycles instead of millions, so a completion on exactly the last allowed poll and one a single poll too late can both be placed directly. A behavioural engine model answers each run with a completion, a failure, both bits together, or silence. It also checks every start word and seed against the run order that the bench expects.

// File: rtl/mst_pkg.sv
package mst_pkg;
    localparam int SEED_LIST_LEN = 8;
    localparam int SEL_W         = 3;
    localparam int CTRL_W        = 8;
    localparam int SEED_W        = 32;
    localparam logic [CTRL_W-1:0] SINGLE_BASE = 8'h85;
    localparam logic [CTRL_W-1:0] BURST_BASE  = 8'hC1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CLR,
        ST_KICK,
        ST_POLL,
        ST_NEXT
    } mst_state_e;
endpackage

// File: rtl/mst_seed_rom.sv
module mst_seed_rom
    import mst_pkg::*;
(
    input  logic [$clog2(SEED_LIST_LEN)-1:0] idx,
    output logic [SEED_W-1:0]                word
);
    always_comb begin
        case (idx)
            3'd0:    word = 32'hcc33cc33;
            3'd1:    word = 32'hff00ff00;
            3'd2:    word = 32'haa55aa55;
            3'd3:    word = 32'h88778877;
            3'd4:    word = 32'h92cc4d6e;
            3'd5:    word = 32'h543d3cde;
            3'd6:    word = 32'hf1e843c7;
            default: word = 32'h7c61d253;
        endcase
    end
endmodule

// File: rtl/mst_ctrl_enc.sv
module mst_ctrl_enc
    import mst_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic              burst,
    output logic [CTRL_W-1:0] word
);
    logic [CTRL_W-1:0] sel_field;

    always_comb begin
        sel_field = CTRL_W'({sel, 3'b000});
        word      = (burst ? BURST_BASE : SINGLE_BASE) | sel_field;
    end
endmodule

// File: rtl/mst_poll_timer.sv
module mst_poll_timer #(
    parameter int LIMIT = 5000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic last
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)     cnt_d = '0;
        else if (en) cnt_d = cnt_q + 1'b1;
        last = (cnt_q == TW'(LIMIT - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mst_seq.sv
module mst_seq
    import mst_pkg::*;
#(
    parameter int NUM_SEEDS  = 2,
    parameter int POLL_LIMIT = 5000000,
    parameter int STAT_W     = 16,
    parameter int CNT_W      = $clog2(NUM_SEEDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [STAT_W-1:0] eng_status,
    output logic [7:0]        eng_ctrl,
    output logic [31:0]       seed_val,
    output logic              done,
    output logic              err,
    output logic [CNT_W-1:0]  pass_cnt,
    output logic [CNT_W-1:0]  fail_cnt
);
    localparam int IDX_W    = $clog2(SEED_LIST_LEN);
    localparam int BIT_CMPL = 12;
    localparam int BIT_FAIL = 13;
    localparam logic [SEL_W-1:0] SEL_LAST = '1;

    typedef struct packed {
        mst_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  used;
        logic [SEL_W-1:0]  sel;
        logic              burst;
        logic [CTRL_W-1:0] ctrl;
        logic [SEED_W-1:0] seed;
        logic [CNT_W-1:0]  npass;
        logic [CNT_W-1:0]  nfail;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;

    logic [SEED_W-1:0] rom_word;
    logic [CTRL_W-1:0] start_word;
    logic              tmr_clr, tmr_en, tmr_last;
    logic              st_cmpl, st_fail;

    mst_seed_rom u_rom (
        .idx  (s_q.idx),
        .word (rom_word)
    );

    mst_ctrl_enc u_enc (
        .sel   (s_q.sel),
        .burst (s_q.burst),
        .word  (start_word)
    );

    mst_poll_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .en    (tmr_en),
        .last  (tmr_last)
    );

    assign st_cmpl = eng_status[BIT_CMPL];
    assign st_fail = eng_status[BIT_FAIL];

    always_comb begin
        s_d     = s_q;
        tmr_clr = 1'b0;
        tmr_en  = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st    = ST_LOAD;
                    s_d.idx   = '0;
                    s_d.used  = '0;
                    s_d.npass = '0;
                    s_d.nfail = '0;
                    s_d.done  = 1'b0;
                end
            end
            ST_LOAD: begin
                s_d.seed  = rom_word;
                s_d.sel   = '0;
                s_d.burst = 1'b0;
                s_d.st    = ST_CLR;
            end
            ST_CLR: begin
                s_d.ctrl = '0;
                s_d.st   = ST_KICK;
            end
            ST_KICK: begin
                s_d.ctrl = start_word;
                tmr_clr  = 1'b1;
                s_d.st   = ST_POLL;
            end
            ST_POLL: begin
                if (st_fail) begin
                    s_d.ctrl  = '0;
                    s_d.nfail = s_q.nfail + 1'b1;
                    s_d.st    = ST_NEXT;
                end else if (st_cmpl) begin
                    s_d.ctrl = '0;
                    if (s_q.burst && s_q.sel == SEL_LAST) begin
                        s_d.npass = s_q.npass + 1'b1;
                        s_d.st    = ST_NEXT;
                    end else begin
                        if (s_q.sel == SEL_LAST) s_d.burst = 1'b1;
                        s_d.sel = s_q.sel + 1'b1;
                        s_d.st  = ST_CLR;
                    end
                end else if (tmr_last) begin
                    s_d.ctrl  = '0;
                    s_d.nfail = s_q.nfail + 1'b1;
                    s_d.st    = ST_NEXT;
                end else begin
                    tmr_en = 1'b1;
                end
            end
            ST_NEXT: begin
                if (s_q.used == CNT_W'(NUM_SEEDS - 1)) begin
                    s_d.done = 1'b1;
                    s_d.st   = ST_IDLE;
                end else begin
                    s_d.used = s_q.used + 1'b1;
                    s_d.idx  = s_q.idx + 1'b1;
                    s_d.st   = ST_LOAD;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign eng_ctrl = s_q.ctrl;
    assign seed_val = s_q.seed;
    assign done     = s_q.done;
    assign err      = s_q.done && (s_q.nfail != '0);
    assign pass_cnt = s_q.npass;
    assign fail_cnt = s_q.nfail;
endmodule

// File: rtl/mst_seq_chk.sv
module mst_seq_chk #(
    parameter int NUM_SEEDS = 2,
    parameter int CNT_W     = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       eng_ctrl,
    input logic             done,
    input logic             err,
    input logic [CNT_W-1:0] pass_cnt,
    input logic [CNT_W-1:0] fail_cnt
);
    AST_CTRL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_ctrl != 8'h00) |-> ((eng_ctrl & 8'hC7) == 8'h85 || (eng_ctrl & 8'hC7) == 8'hC1)); // R4

    AST_ZERO_BEFORE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_ctrl != 8'h00 && !$stable(eng_ctrl)) |-> ($past(eng_ctrl) == 8'h00)); // R5

    AST_COUNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((32'(pass_cnt) + 32'(fail_cnt)) == NUM_SEEDS)); // R8

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && fail_cnt != '0)); // R9

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (eng_ctrl == 8'h00)); // R9

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> ($stable(pass_cnt) && $stable(fail_cnt))); // R10
endmodule

bind mst_seq mst_seq_chk #(.NUM_SEEDS(NUM_SEEDS), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .eng_ctrl (eng_ctrl),
    .done     (done),
    .err      (err),
    .pass_cnt (pass_cnt),
    .fail_cnt (fail_cnt)
);

// File: tb/sim_mst_seq.sv
module sim_mst_seq;
    localparam int NS  = 10;
    localparam int LIM = 12;
    localparam int CW  = $clog2(NS + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [15:0]   eng_status = '0;
    logic [7:0]    eng_ctrl;
    logic [31:0]   seed_val;
    logic          done, err;
    logic [CW-1:0] pass_cnt, fail_cnt;

    always #2 clk = ~clk;

    mst_seq #(.NUM_SEEDS(NS), .POLL_LIMIT(LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .eng_status(eng_status),
        .eng_ctrl(eng_ctrl), .seed_val(seed_val), .done(done), .err(err),
        .pass_cnt(pass_cnt), .fail_cnt(fail_cnt)
    );

    int n_chk = 0;
    int n_bad = 0;

    // scenario: run index at which each seed goes wrong (16 = never) and how
    // kind 0 = fail bit, 1 = fail and complete bits together, 2 = no answer
    int fail_run [NS];
    int fail_kind[NS];
    int fixed_lat = -1;

    // engine model bookkeeping
    int seed_no = 0;
    int run_k   = 0;
    int lat_left = 0;
    int cur_out  = 0;
    int cur_lat  = 0;
    bit active   = 1'b0;
    logic [7:0] prev_ctrl = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_seed(input int k);
        case (k % 8)
            0: return 32'hcc33cc33;
            1: return 32'hff00ff00;
            2: return 32'haa55aa55;
            3: return 32'h88778877;
            4: return 32'h92cc4d6e;
            5: return 32'h543d3cde;
            6: return 32'hf1e843c7;
            default: return 32'h7c61d253;
        endcase
    endfunction

    function automatic logic [7:0] exp_word(input int r);
        if (r < 8) return 8'h85 | 8'(r << 3);
        return 8'hC1 | 8'((r - 8) << 3);
    endfunction

    function automatic bit seed_passes(input int s);
        if (fixed_lat >= LIM) return 1'b0;
        return fail_run[s] >= 16;
    endfunction

    // behavioural test engine, driven away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            eng_status = '0;
            active = 1'b0;
            prev_ctrl = '0;
        end else begin
            if (eng_ctrl != 8'h00 && prev_ctrl != 8'h00 && eng_ctrl != prev_ctrl)
                chk(1'b0, "R5 start word without clear", 64'(eng_ctrl), 64'h0);
            if (eng_ctrl == 8'h00) begin
                if (prev_ctrl != 8'h00) begin
                    if (cur_out == 0 && cur_lat < LIM && run_k < 15) run_k++;
                    else begin
                        seed_no++;
                        run_k = 0;
                    end
                end
                eng_status = '0;
                active = 1'b0;
            end else if (prev_ctrl == 8'h00) begin
                chk(eng_ctrl == exp_word(run_k), "R3/R4 run word", 64'(eng_ctrl), 64'(exp_word(run_k)));
                chk(seed_val == exp_seed(seed_no), "R2 seed value", 64'(seed_val), 64'(exp_seed(seed_no)));
                if (seed_no < NS) cur_out = (fail_run[seed_no] == run_k) ? 1 + fail_kind[seed_no] : 0;
                else cur_out = 0;
                cur_lat  = (fixed_lat >= 0) ? fixed_lat : int'($urandom % 6);
                lat_left = cur_lat;
                active   = 1'b1;
            end else if (active) begin
                lat_left--;
            end
            if (eng_ctrl != 8'h00 && active && lat_left == 0) begin
                case (cur_out)
                    0: eng_status[12] = 1'b1;
                    1: eng_status[13] = 1'b1;
                    2: eng_status[13:12] = 2'b11;
                    default: ;
                endcase
            end
            prev_ctrl = eng_ctrl;
        end
    end

    bit hung = 1'b0;

    task automatic run_test(input string name, input int mid_start_at);
        int exp_pass = 0;
        int waited = 0;
        for (int s = 0; s < NS; s++) if (seed_passes(s)) exp_pass++;
        seed_no = 0;
        run_k = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, {"R10 done cleared ", name}, 64'(done), 64'h0);
        while (!done && !hung) begin
            @(negedge clk);
            waited++;
            if (waited == mid_start_at) start = 1'b1;
            else start = 1'b0;
            if (waited > 20000) hung = 1'b1;
        end
        start = 1'b0;
        if (hung) begin
            chk(1'b0, {"watchdog ", name}, 64'(waited), 64'h0);
            return;
        end
        chk(32'(pass_cnt) == exp_pass, {"R6/R8 pass count ", name}, 64'(pass_cnt), 64'(exp_pass));
        chk(32'(fail_cnt) == NS - exp_pass, {"R7/R8 fail count ", name}, 64'(fail_cnt), 64'(NS - exp_pass));
        chk(err == (exp_pass != NS), {"R9 err flag ", name}, 64'(err), 64'(exp_pass != NS));
        chk(seed_no == NS, {"R8 seeds used ", name}, 64'(seed_no), 64'(NS));
        chk(eng_ctrl == 8'h00, {"R5 ctrl idle ", name}, 64'(eng_ctrl), 64'h0);
        repeat (5) @(negedge clk);
        chk(done == 1'b1, {"R9 done held ", name}, 64'(done), 64'h1);
    endtask

    task automatic all_pass();
        for (int s = 0; s < NS; s++) begin
            fail_run[s] = 16;
            fail_kind[s] = 0;
        end
    endtask

    task automatic random_plan();
        for (int s = 0; s < NS; s++) begin
            fail_run[s]  = ($urandom % 2) ? 16 : int'($urandom % 16);
            fail_kind[s] = int'($urandom % 3);
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        all_pass();
        repeat (3) @(negedge clk);
        chk(eng_ctrl == 8'h00, "R1 ctrl at reset", 64'(eng_ctrl), 64'h0);
        chk(done == 1'b0 && err == 1'b0, "R1 flags at reset", 64'({done, err}), 64'h0);
        chk(pass_cnt == '0 && fail_cnt == '0, "R1 counts at reset", 64'({pass_cnt, fail_cnt}), 64'h0);
        rst_n = 1'b1;

        all_pass();
        fixed_lat = -1;
        run_test("all pass", 0);

        fixed_lat = LIM - 1;
        run_test("R7 answer on last poll", 0);

        fixed_lat = LIM;
        run_test("R7 one poll late", 0);

        fixed_lat = -1;
        all_pass();
        fail_run[0] = 15; fail_kind[0] = 1;
        fail_run[1] = 0;  fail_kind[1] = 0;
        fail_run[2] = 7;  fail_kind[2] = 2;
        fail_run[9] = 8;  fail_kind[9] = 1;
        run_test("R6 directed failures", 0);

        random_plan();
        run_test("R10 start while busy", 37);

        all_pass();
        run_test("R10 counters cleared", 0);

        for (int t = 0; t < 8 && !hung; t++) begin
            random_plan();
            run_test("random", (t % 2) ? 200 : 0);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule